// File: doc/BRIEF.md
# Hardware RAM Size Probe Engine

This block finds where a single contiguous RAM region ends by walking through it with a simple synchronous memory master port. It needs no processor and no scratch memory. A start pulse arms the probe.

The engine first plants a zero in the first probe word, one word above the base address. It then moves upward in 1 KB steps. At each step it:

- reads the word, and stops if the word holds the first probe address, because that value can only appear there by address aliasing;
- writes the word's own address into it and reads it back, and stops if the value differs, because the probe has left writable memory.

The probe also stops once a parameterised number of kilobytes has passed. When it stops, the engine reports the number of good kilobytes, the matching top address and a stop cause, and holds them until the next start.

A typical use is in boot or bring-up logic. There the memory size must be known before a stack pointer or an allocator is set up. The memory behind the port is treated as a black box that may wrap, may drop writes, or may end.

Top module: `ram_size_probe`

## Requirements
- R1: A start pulse seen while the engine is idle or finished begins a new probe: busy rises on the next cycle and done falls. A start pulse seen while busy is ignored, and the run finishes with the same results as without it.
- R2: The first memory transaction of every run is a write of value zero to address BASE_ADDR + 4.
- R3: Each probe step first reads the probe word. If the data equals BASE_ADDR + 4, the run stops with cause code 1 (alias found) and the step is not counted.
- R4: Otherwise the step writes the probe address into the probe word and reads it back. If the read-back value differs, the run stops with cause code 2 (read-back mismatch) and the step is not counted.
- R5: A step that passes both reads adds one to the kilobyte count and moves the probe address up by 1024. When the count reaches MAX_KB, the run stops with cause code 0 (limit reached).
- R6: When done is high, size_kb_o equals the number of passed steps, and top_addr_o equals BASE_ADDR + 1024 × size_kb_o. This is the final probe address minus 4.
- R7: The port carries one transaction at a time. A request stays high with stable address, direction and write data until ready is high. A write completes at acceptance. A read completes when rvalid pulses, at least one cycle after acceptance.
- R8: done, cause_o, size_kb_o and top_addr_o hold their values until the next start pulse.
- R9: With ready always high and read data one cycle after acceptance, done rises on the clock edge that lies the following number of edges after the edge that samples start:
  - 2 + 8·MAX_KB for a limit stop;
  - 2 + 8·k + 3 for an alias stop after k passed steps;
  - 2 + 8·k + 8 for a mismatch stop after k passed steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle start request |
| mem_req_o | output | 1 | Memory transaction request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Byte address of the transaction |
| mem_wdata_o | output | DATA_W | Write data |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rdata_i | input | DATA_W | Read data, valid with mem_rvalid_i |
| mem_rvalid_i | input | 1 | Read data valid pulse |
| busy_o | output | 1 | Probe in progress |
| done_o | output | 1 | Probe finished; results valid |
| cause_o | output | 2 | Stop cause: 0 limit, 1 alias, 2 mismatch |
| top_addr_o | output | ADDR_W | Last good address boundary (BASE_ADDR + 1024 × size) |
| size_kb_o | output | $clog2(MAX_KB+1) | Kilobytes found |

## Verification
Results are due only once done rises. The bench waits for done and samples on the falling edge, so a variable memory delay cannot move the sampling point.

On runs with a zero-wait memory, the bench counts clock edges from the edge that samples start up to the first edge after which done reads high. It compares that count with the R9 formula. The formula is built from 2 cycles per write and 3 per read: one cycle to launch the request, one to accept it and, for a read, one for the data.

The R8 checks sample the results again several cycles after done rises. Every other check is taken at the first falling edge after done rises.

// File: rtl/probe_pkg.sv
// Package: shared encodings for the RAM size probe engine.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package probe_pkg;

    // Stop cause reported on cause_o.
    typedef enum logic [1:0] {
        CAUSE_LIMIT    = 2'd0,
        CAUSE_ALIAS    = 2'd1,
        CAUSE_MISMATCH = 2'd2
    } stop_cause_e;

    // Sequencer state.
    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_PLANT,
        SEQ_READ_CHK,
        SEQ_WRITE_OWN,
        SEQ_READ_BACK,
        SEQ_FINISHED
    } seq_state_e;

    // Bus master phase.
    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_REQ,
        BUS_WAIT_DATA
    } bus_phase_e;

endpackage

// File: rtl/probe_bus_master.sv
// Module: probe_bus_master
// Turns a held command from the sequencer into one memory transaction.
// A command is launched one cycle after cmd_valid is seen in the idle phase.
// A write completes on acceptance (req && ready); a read completes on rvalid.
// Assumes: the memory raises rvalid at least one cycle after it accepts a read,
// and cmd_valid is deasserted or changed on the cycle after cmd_done.
module probe_bus_master #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_we,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_done,
    output logic [DATA_W-1:0] cmd_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rvalid
);
    import probe_pkg::*;

    bus_phase_e        phase_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              accept;

    assign accept = (phase_q == BUS_REQ) && mem_ready;

    // Phase register: launch, wait for acceptance, wait for read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= BUS_IDLE;
        end else begin
            unique case (phase_q)
                BUS_IDLE:      if (cmd_valid) phase_q <= BUS_REQ;
                BUS_REQ:       if (accept) phase_q <= we_q ? BUS_IDLE : BUS_WAIT_DATA;
                BUS_WAIT_DATA: if (mem_rvalid) phase_q <= BUS_IDLE;
                default:       phase_q <= BUS_IDLE;
            endcase
        end
    end

    // Command capture: hold address, direction and data for the whole request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (phase_q == BUS_IDLE && cmd_valid) begin
            we_q    <= cmd_we;
            addr_q  <= cmd_addr;
            wdata_q <= cmd_wdata;
        end
    end

    // Port drive and completion strobe.
    always_comb begin
        mem_req   = (phase_q == BUS_REQ);
        mem_we    = we_q;
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        cmd_done  = (accept && we_q) || ((phase_q == BUS_WAIT_DATA) && mem_rvalid);
        cmd_rdata = mem_rdata;
    end

endmodule

// File: rtl/probe_step_counter.sv
// Module: probe_step_counter
// Holds the current probe address and the count of passed 1 KB steps.
// load restarts at the first probe address; advance moves one step up.
// Assumes: load and advance are never high together; MAX_KB >= 1.
module probe_step_counter #(
    parameter int unsigned        ADDR_W     = 32,
    parameter logic [ADDR_W-1:0]  BASE_ADDR  = '0,
    parameter int unsigned        MAX_KB     = 1024,
    parameter int unsigned        STEP_BYTES = 1024,
    parameter int unsigned        WORD_OFS   = 4,
    parameter int unsigned        KB_W       = $clog2(MAX_KB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    output logic [ADDR_W-1:0] probe_addr,
    output logic [ADDR_W-1:0] first_addr,
    output logic [KB_W-1:0]   kb_count,
    output logic              last_step
);
    localparam logic [ADDR_W-1:0] FIRST_ADDR = BASE_ADDR + ADDR_W'(WORD_OFS);
    localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(STEP_BYTES);
    localparam logic [KB_W-1:0]   LAST_COUNT = KB_W'(MAX_KB - 1);

    logic [ADDR_W-1:0] addr_q;
    logic [KB_W-1:0]   count_q;

    // Address and step count registers.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            addr_q  <= FIRST_ADDR;
            count_q <= '0;
        end else if (advance) begin
            addr_q  <= addr_q + STEP;
            count_q <= count_q + KB_W'(1);
        end
    end

    // Outputs, including the flag that the next advance reaches the limit.
    always_comb begin
        probe_addr = addr_q;
        first_addr = FIRST_ADDR;
        kb_count   = count_q;
        last_step  = (count_q == LAST_COUNT);
    end

endmodule

// File: rtl/probe_seq_ctrl.sv
// Module: probe_seq_ctrl
// Sequencer of the probe: plant zero, then per step read-check, write-own,
// read-back, and decide to stop or advance. Records the stop cause.
// Assumes: cmd_done pulses exactly once per command, and cmd_rdata is valid
// with it on reads.
module probe_seq_ctrl #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmd_done,
    input  logic [DATA_W-1:0] cmd_rdata,
    input  logic [ADDR_W-1:0] probe_addr,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic              last_step,
    output logic              cmd_valid,
    output logic              cmd_we,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata,
    output logic              load,
    output logic              advance,
    output logic              busy,
    output logic              done,
    output logic [1:0]        cause
);
    import probe_pkg::*;

    seq_state_e  state_q, state_d;
    stop_cause_e cause_q, cause_d;
    logic        accept_start;
    logic        alias_hit;
    logic        back_bad;

    assign accept_start = start && (state_q == SEQ_IDLE || state_q == SEQ_FINISHED);
    assign alias_hit    = (cmd_rdata == DATA_W'(first_addr));
    assign back_bad     = (cmd_rdata != DATA_W'(probe_addr));

    // State and cause registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cause_q <= CAUSE_LIMIT;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    // Next-state logic and counter control.
    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        load    = 1'b0;
        advance = 1'b0;
        if (accept_start) begin
            state_d = SEQ_PLANT;
            load    = 1'b1;
        end else begin
            unique case (state_q)
                SEQ_PLANT:     if (cmd_done) state_d = SEQ_READ_CHK;
                SEQ_READ_CHK: begin
                    if (cmd_done) begin
                        if (alias_hit) begin
                            state_d = SEQ_FINISHED;
                            cause_d = CAUSE_ALIAS;
                        end else begin
                            state_d = SEQ_WRITE_OWN;
                        end
                    end
                end
                SEQ_WRITE_OWN: if (cmd_done) state_d = SEQ_READ_BACK;
                SEQ_READ_BACK: begin
                    if (cmd_done) begin
                        if (back_bad) begin
                            state_d = SEQ_FINISHED;
                            cause_d = CAUSE_MISMATCH;
                        end else begin
                            advance = 1'b1;
                            if (last_step) begin
                                state_d = SEQ_FINISHED;
                                cause_d = CAUSE_LIMIT;
                            end else begin
                                state_d = SEQ_READ_CHK;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Command selection for the bus master.
    always_comb begin
        cmd_valid = 1'b0;
        cmd_we    = 1'b0;
        cmd_addr  = probe_addr;
        cmd_wdata = '0;
        unique case (state_q)
            SEQ_PLANT: begin
                cmd_valid = 1'b1;
                cmd_we    = 1'b1;
                cmd_addr  = first_addr;
            end
            SEQ_READ_CHK, SEQ_READ_BACK: cmd_valid = 1'b1;
            SEQ_WRITE_OWN: begin
                cmd_valid = 1'b1;
                cmd_we    = 1'b1;
                cmd_wdata = DATA_W'(probe_addr);
            end
            default: ;
        endcase
    end

    // Status outputs.
    always_comb begin
        busy  = !(state_q == SEQ_IDLE || state_q == SEQ_FINISHED);
        done  = (state_q == SEQ_FINISHED);
        cause = cause_q;
    end

endmodule

// File: rtl/ram_size_probe.sv
// Module: ram_size_probe (top)
// Finds the top of one contiguous RAM region. It writes each probe word's own
// address, reads it back, and detects aliasing via a marker planted first.
// Assumes: DATA_W >= ADDR_W so an address fits in one word; the memory
// follows the req/ready, rvalid handshake of probe_bus_master.
module ram_size_probe #(
    parameter int unsigned       ADDR_W     = 32,
    parameter int unsigned       DATA_W     = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = '0,
    parameter int unsigned       MAX_KB     = 1024,
    parameter int unsigned       STEP_BYTES = 1024,
    parameter int unsigned       WORD_OFS   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    output logic                         mem_req_o,
    output logic                         mem_we_o,
    output logic [ADDR_W-1:0]            mem_addr_o,
    output logic [DATA_W-1:0]            mem_wdata_o,
    input  logic                         mem_ready_i,
    input  logic [DATA_W-1:0]            mem_rdata_i,
    input  logic                         mem_rvalid_i,
    output logic                         busy_o,
    output logic                         done_o,
    output logic [1:0]                   cause_o,
    output logic [ADDR_W-1:0]            top_addr_o,
    output logic [$clog2(MAX_KB+1)-1:0]  size_kb_o
);
    localparam int unsigned KB_W = $clog2(MAX_KB + 1);

    logic              cmd_valid, cmd_we, cmd_done;
    logic [ADDR_W-1:0] cmd_addr, probe_addr, first_addr;
    logic [DATA_W-1:0] cmd_wdata, cmd_rdata;
    logic              load, advance, last_step;
    logic [KB_W-1:0]   kb_count;

    probe_step_counter #(
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .MAX_KB(MAX_KB),
        .STEP_BYTES(STEP_BYTES), .WORD_OFS(WORD_OFS), .KB_W(KB_W)
    ) u_counter (
        .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
        .probe_addr(probe_addr), .first_addr(first_addr),
        .kb_count(kb_count), .last_step(last_step)
    );

    probe_seq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start_i),
        .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
        .probe_addr(probe_addr), .first_addr(first_addr), .last_step(last_step),
        .cmd_valid(cmd_valid), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .load(load), .advance(advance),
        .busy(busy_o), .done(done_o), .cause(cause_o)
    );

    probe_bus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
        .mem_req(mem_req_o), .mem_we(mem_we_o), .mem_addr(mem_addr_o),
        .mem_wdata(mem_wdata_o), .mem_ready(mem_ready_i),
        .mem_rdata(mem_rdata_i), .mem_rvalid(mem_rvalid_i)
    );

    // Result outputs: top boundary is the final probe address less the word offset.
    always_comb begin
        top_addr_o = probe_addr - ADDR_W'(WORD_OFS);
        size_kb_o  = kb_count;
    end

endmodule

// File: rtl/ram_size_probe_checker.sv
// Module: ram_size_probe_checker
// Protocol and result properties of ram_size_probe, observed at its ports.
// Assumes: bound to every instance of ram_size_probe.
module ram_size_probe_checker #(
    parameter int unsigned       ADDR_W     = 32,
    parameter int unsigned       DATA_W     = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = '0,
    parameter int unsigned       MAX_KB     = 1024,
    parameter int unsigned       STEP_BYTES = 1024,
    parameter int unsigned       KB_W       = $clog2(MAX_KB + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_wdata_o,
    input logic              mem_ready_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [1:0]        cause_o,
    input logic [ADDR_W-1:0] top_addr_o,
    input logic [KB_W-1:0]   size_kb_o
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)); // R7
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o); // R7
    AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o && !done_o); // R1
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o)); // R1
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> done_o && $stable(cause_o) && $stable(top_addr_o) && $stable(size_kb_o)); // R8
    AST_SIZE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(size_kb_o) <= MAX_KB); // R5
    AST_TOP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> top_addr_o == BASE_ADDR + ADDR_W'(32'(size_kb_o) * STEP_BYTES)); // R6
    AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> cause_o != 2'd3); // R3
endmodule

bind ram_size_probe ram_size_probe_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR),
    .MAX_KB(MAX_KB), .STEP_BYTES(STEP_BYTES), .KB_W($clog2(MAX_KB + 1))
) u_checker (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i),
    .busy_o(busy_o), .done_o(done_o), .cause_o(cause_o),
    .top_addr_o(top_addr_o), .size_kb_o(size_kb_o)
);

// File: tb/ram_size_probe_tb.sv
`timescale 1ns/1ps
module ram_size_probe_tb;
    localparam int unsigned       AW    = 32;
    localparam int unsigned       DW    = 32;
    localparam logic [AW-1:0]     BASE  = 32'h0001_0000;
    localparam int unsigned       MAXKB = 16;
    localparam int unsigned       KBW   = $clog2(MAXKB + 1);
    localparam logic [AW-1:0]     FIRST = BASE + 32'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic mem_req, mem_we, mem_ready = 1'b0, mem_rvalid = 1'b0;
    logic [AW-1:0] mem_addr, top_addr;
    logic [DW-1:0] mem_wdata, mem_rdata = '0;
    logic busy, done;
    logic [1:0] cause;
    logic [KBW-1:0] size_kb;

    int tests = 0;
    int fails = 0;

    // Memory model configuration: mode 0 = ends after size, mode 1 = wraps.
    int mode = 0;
    int region_kb = 4;
    bit zero_wait = 1'b1;
    logic [DW-1:0] store [0:63];

    // First transaction of the current run.
    int txn_n = 0;
    logic first_we;
    logic [AW-1:0] first_addr_seen;
    logic [DW-1:0] first_wdata;
    int pend_cnt = 0;
    logic [DW-1:0] pend_data;

    always #2 clk = ~clk;

    ram_size_probe #(
        .ADDR_W(AW), .DATA_W(DW), .BASE_ADDR(BASE), .MAX_KB(MAXKB),
        .STEP_BYTES(1024), .WORD_OFS(4)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready),
        .mem_rdata_i(mem_rdata), .mem_rvalid_i(mem_rvalid),
        .busy_o(busy), .done_o(done), .cause_o(cause),
        .top_addr_o(top_addr), .size_kb_o(size_kb)
    );

    function automatic int slot_of(input logic [AW-1:0] a);
        return int'((a - BASE) >> 10);
    endfunction

    function automatic logic [DW-1:0] mem_read(input logic [AW-1:0] a);
        int k = slot_of(a);
        if (mode == 1) return store[k % region_kb];
        if (k < region_kb) return store[k];
        return 32'hA5A5_0000 | DW'(k);
    endfunction

    // Memory model: random ready, random read latency, optional wrap.
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        mem_ready  <= zero_wait ? 1'b1 : ($urandom_range(0, 2) != 0);
        if (pend_cnt > 0) begin
            pend_cnt = pend_cnt - 1;
            if (pend_cnt == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= pend_data;
            end
        end
        if (start_i) txn_n = 0;
        if (rst_n && mem_req && mem_ready) begin
            if (txn_n == 0) begin
                first_we        = mem_we;
                first_addr_seen = mem_addr;
                first_wdata     = mem_wdata;
            end
            txn_n = txn_n + 1;
            if (mem_we) begin
                if (mode == 1) store[slot_of(mem_addr) % region_kb] = mem_wdata;
                else if (slot_of(mem_addr) < region_kb) store[slot_of(mem_addr)] = mem_wdata;
            end else begin
                int lat = zero_wait ? 1 : int'($urandom_range(1, 3));
                if (lat == 1) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= mem_read(mem_addr);
                end else begin
                    pend_cnt  = lat - 1;
                    pend_data = mem_read(mem_addr);
                end
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_kb(input int m, input int s);
        return (s >= int'(MAXKB)) ? int'(MAXKB) : s;
    endfunction

    function automatic int exp_cause(input int m, input int s);
        if (s >= int'(MAXKB)) return 0;
        return (m == 1) ? 1 : 2;
    endfunction

    function automatic int exp_lat(input int m, input int s);
        int c = exp_cause(m, s);
        if (c == 0) return 2 + 8 * int'(MAXKB);
        if (c == 1) return 2 + 8 * s + 3;
        return 2 + 8 * s + 8;
    endfunction

    // One probe run against a configured memory, with all result checks.
    task automatic run_probe(input int m, input int s, input bit zw, input bit poke);
        int n = 0;
        mode = m; region_kb = s; zero_wait = zw;
        @(negedge clk);
        start_i = 1'b1;
        @(posedge clk);
        #1 start_i = 1'b0;
        while (!done && n < 5000) begin
            @(posedge clk);
            #1;
            n++;
            if (poke && n == 7) start_i = 1'b1;      // R1: start while busy
            else start_i = 1'b0;
        end
        @(negedge clk);
        if (n >= 5000) begin
            tests++; fails++;
            $display("FAIL watchdog: run did not finish, actual %0d expected <5000", n);
            return;
        end
        check("R3/R4/R5 cause", 64'(cause), 64'(exp_cause(m, s)));
        check("R5/R6 size", 64'(size_kb), 64'(exp_kb(m, s)));
        check("R6 top", 64'(top_addr), 64'(BASE + AW'(exp_kb(m, s) * 1024)));
        if (zw && !poke) check("R9 latency", 64'(n), 64'(exp_lat(m, s)));
        if (!poke) check("R2 first txn", {first_we, first_addr_seen, 31'(first_wdata)},
                         {1'b1, FIRST, 31'd0});
        if (poke) check("R1 ignored start", 64'(busy), 64'd0);
    endtask

    initial begin
        int saved_kb, saved_cause;
        void'($urandom(32'd4242));
        for (int i = 0; i < 64; i++) store[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset done", 64'(done), 64'd0);
        check("R1 reset busy", 64'(busy), 64'd0);
        check("R7 reset req", 64'(mem_req), 64'd0);
        rst_n = 1'b1;

        run_probe(0, 5, 1'b1, 1'b0);      // R4 mismatch
        run_probe(1, 3, 1'b1, 1'b0);      // R3 alias
        run_probe(0, 20, 1'b1, 1'b0);     // R5 limit
        run_probe(1, 16, 1'b1, 1'b0);     // R5 limit exactly at size
        run_probe(0, 0, 1'b1, 1'b0);      // R4 nothing writable
        run_probe(1, 1, 1'b1, 1'b0);      // R3 smallest alias
        store[0] = FIRST;                 // R2 stale marker from an older run
        run_probe(0, 8, 1'b1, 1'b0);
        run_probe(1, 4, 1'b0, 1'b0);
        run_probe(1, 4, 1'b0, 1'b0);      // R2 rerun over own leftovers
        run_probe(1, 6, 1'b0, 1'b1);      // R1 start while busy ignored

        // R8: results hold after done.
        saved_kb = int'(size_kb); saved_cause = int'(cause);
        repeat (6) @(negedge clk);
        check("R8 done held", 64'(done), 64'd1);
        check("R8 size held", 64'(size_kb), 64'(saved_kb));
        check("R8 cause held", 64'(cause), 64'(saved_cause));

        for (int r = 0; r < 24; r++) begin
            int m = int'($urandom_range(0, 1));
            int s = (m == 1) ? int'($urandom_range(1, 20)) : int'($urandom_range(0, 20));
            run_probe(m, s, bit'($urandom_range(0, 1)), 1'b0);   // R7 random handshake
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        fails++; tests++;
        $display("FAIL watchdog: global timeout, actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule